// File: doc/BRIEF.md
# CAN Error Counter with Bus-Off Recovery

This block keeps the transmit and receive error counters of one CAN node and derives the fault-confinement status from them. The status covers the warning, error-passive and bus-off indications. The protocol engine sends increment requests, each with a step size, and single-step decrement requests. It also sends a strobe each time it sees a sequence of eleven recessive bits. Software can reprogram the warning threshold, and it owns the node's INIT control bit and a sticky alert flag.

An increment that would push the transmit counter past its top value takes the node off the bus. While the node is off the bus, normal counting stops. The receive counter then counts idle sequences as the recovery progress. Its value starts at 1 and rises by one per idle strobe. When it reaches the warning threshold, warning and bus-off are shown together and a pre-warning interrupt is raised. After the configured number of idle sequences, both counters return to zero, bus-off and warning drop, and the alert flag is set. INIT stays set, so software must restart the node on purpose. Each event raises a one-cycle interrupt pulse in the same cycle its status changes.

Top module: `can_errcnt_recovery`

## Requirements
- R1: Outside bus-off, an increment request adds its step to the counter and a decrement subtracts one. If both arrive in the same cycle, the increment wins. The receive counter saturates at 255. Both counters stay at 0 when decremented from 0.
- R2: The warning level resets to 0x60 and a level write replaces it. Warning is active while either counter is at or above the level. A rising warning outside bus-off gives a one-cycle warning interrupt in the same cycle.
- R3: Error-passive is active when either counter is 128 or more, and never while bus-off.
- R4: A transmit increment whose result would exceed 255 enters bus-off in the next cycle. In that cycle both counters read 1, INIT is 1 and the bus-off interrupt pulses.
- R5: While bus-off, increment and decrement requests leave both counters unchanged.
- R6: While bus-off, each idle strobe adds one to the receive counter. Outside bus-off the idle strobe has no effect on either counter.
- R7: When the receive counter reaches the warning level during bus-off, warning and bus-off are both 1 and the pre-warning interrupt pulses. The warning interrupt stays 0.
- R8: Recovery completes on the idle strobe seen while the receive counter equals 128, which is the 128th idle sequence. Bus-off and warning clear, both counters read 0, alert sets with a one-cycle alert interrupt, and INIT stays 1.
- R9: An INIT write takes the written value. A write of 0 is ignored while bus-off, and entering bus-off overrides a write of 0 in the same cycle.
- R10: An alert-clear write clears alert. A recovery completing in the same cycle wins and leaves alert at 1.
- R11: After reset the counters are 0, the level is 0x60, INIT is 1, and all other status and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_inc_i | input | 1 | Transmit counter increment request |
| tx_amt_i | input | AMT_W | Transmit increment step |
| tx_dec_i | input | 1 | Transmit counter decrement-by-one request |
| rx_inc_i | input | 1 | Receive counter increment request |
| rx_amt_i | input | AMT_W | Receive increment step |
| rx_dec_i | input | 1 | Receive counter decrement-by-one request |
| idle_seq_i | input | 1 | Strobe, one per observed 11-recessive-bit sequence |
| lvl_wr_i | input | 1 | Warning level write enable |
| lvl_val_i | input | CNT_W | Warning level write data |
| init_wr_i | input | 1 | INIT write enable |
| init_val_i | input | 1 | INIT write data |
| alert_clr_i | input | 1 | Clear the alert flag |
| tec_o | output | CNT_W | Transmit error counter |
| rec_o | output | CNT_W | Receive error counter / recovery progress |
| warn_o | output | 1 | Warning status |
| passive_o | output | 1 | Error-passive status |
| busoff_o | output | 1 | Bus-off status |
| init_o | output | 1 | INIT control bit |
| alert_o | output | 1 | Recovery-complete alert flag |
| irq_warn_o | output | 1 | Warning interrupt pulse |
| irq_busoff_o | output | 1 | Bus-off interrupt pulse |
| irq_prewarn_o | output | 1 | Pre-warning interrupt pulse during recovery |
| irq_alert_o | output | 1 | Alert interrupt pulse |

## Verification
Both counters appear directly on the ports, and every status flag is registered from the same next-state values. A wrong counter value or a stuck mode bit is therefore visible in the first cycle after the faulty update. An off-by-one in the recovery compare moves the bus-off release and the alert pulse by exactly one idle strobe. A saturation or floor fault shows up on the very next increment or decrement that hits the limit. Because the interrupts are edge pulses, a bad previous-state register shows as a missing or doubled pulse at the threshold crossing, in that same cycle.

// File: rtl/errcnt_pkg.sv
`timescale 1ns/1ps
package errcnt_pkg;

   typedef enum logic {
      MODE_RUN    = 1'b0,
      MODE_BUSOFF = 1'b1
   } node_mode_e;

   typedef struct packed {
      logic warn;
      logic passive;
      logic irq_warn;
      logic irq_prewarn;
   } lvl_flags_t;

endpackage

// File: rtl/errcnt_cell.sv
`timescale 1ns/1ps
module errcnt_cell #(
   parameter int CNT_W     = 8,
   parameter int AMT_W     = 4,
   parameter bit CARRY_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             inc_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             dec_i,
   input  logic             step_i,
   input  logic             load_one_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_nxt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] MAXV = '1;
   localparam logic [CNT_W:0]   TOPV = {1'b0, MAXV};
   localparam int               PADW = CNT_W + 1 - AMT_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W:0]   sum_w;
   logic             over_w;

   assign sum_w  = {1'b0, cnt_q} + {{PADW{1'b0}}, amt_i};
   assign over_w = sum_w > TOPV;

   always_comb begin
      nxt = cnt_q;
      if (load_one_i) begin
         nxt = {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (clear_i) begin
         nxt = '0;
      end else if (step_i) begin
         if (cnt_q != MAXV) nxt = cnt_q + 1'b1;
      end else if (!freeze_i) begin
         if (inc_i) begin
            nxt = over_w ? MAXV : sum_w[CNT_W-1:0];
         end else if (dec_i && (cnt_q != '0)) begin
            nxt = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= nxt;
   end

   generate
      if (CARRY_OUT) begin : g_carry
         assign ovf_o = inc_i && !freeze_i && over_w;
      end else begin : g_sat
         assign ovf_o = 1'b0;
      end
   endgenerate

   assign cnt_o     = cnt_q;
   assign cnt_nxt_o = nxt;
endmodule

// File: rtl/errcnt_flags.sv
`timescale 1ns/1ps
module errcnt_flags
   import errcnt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int PASS_LVL = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tec_nxt_i,
   input  logic [CNT_W-1:0] rec_nxt_i,
   input  logic [CNT_W-1:0] lvl_nxt_i,
   input  logic             bo_nxt_i,
   output lvl_flags_t       flags_o
);
   localparam logic [CNT_W-1:0] PASS_V = PASS_LVL[CNT_W-1:0];

   lvl_flags_t flg_q;
   logic       warn_n;
   logic       pas_n;

   assign warn_n = (tec_nxt_i >= lvl_nxt_i) || (rec_nxt_i >= lvl_nxt_i);
   assign pas_n  = !bo_nxt_i && ((tec_nxt_i >= PASS_V) || (rec_nxt_i >= PASS_V));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flg_q <= '0;
      end else begin
         flg_q.warn        <= warn_n;
         flg_q.passive     <= pas_n;
         flg_q.irq_warn    <= warn_n && !flg_q.warn && !bo_nxt_i;
         flg_q.irq_prewarn <= warn_n && !flg_q.warn && bo_nxt_i;
      end
   end

   assign flags_o = flg_q;
endmodule

// File: rtl/can_errcnt_recovery.sv
`timescale 1ns/1ps
module can_errcnt_recovery
   import errcnt_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int AMT_W      = 4,
   parameter int WARN_RST   = 8'h60,
   parameter int PASS_LVL   = 128,
   parameter int RECOV_SEQS = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_inc_i,
   input  logic [AMT_W-1:0] tx_amt_i,
   input  logic             tx_dec_i,
   input  logic             rx_inc_i,
   input  logic [AMT_W-1:0] rx_amt_i,
   input  logic             rx_dec_i,
   input  logic             idle_seq_i,
   input  logic             lvl_wr_i,
   input  logic [CNT_W-1:0] lvl_val_i,
   input  logic             init_wr_i,
   input  logic             init_val_i,
   input  logic             alert_clr_i,
   output logic [CNT_W-1:0] tec_o,
   output logic [CNT_W-1:0] rec_o,
   output logic             warn_o,
   output logic             passive_o,
   output logic             busoff_o,
   output logic             init_o,
   output logic             alert_o,
   output logic             irq_warn_o,
   output logic             irq_busoff_o,
   output logic             irq_prewarn_o,
   output logic             irq_alert_o
);
   localparam int               MAX_I   = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] RECOV_V = RECOV_SEQS[CNT_W-1:0];
   localparam logic [CNT_W-1:0] LVL_RV  = WARN_RST[CNT_W-1:0];

   generate
      if (AMT_W < 1 || AMT_W > CNT_W) begin : g_bad_amt
         $error("AMT_W must lie between 1 and CNT_W");
      end
      if (RECOV_SEQS < 2 || RECOV_SEQS > MAX_I) begin : g_bad_recov
         $error("RECOV_SEQS must fit in the counter");
      end
      if (PASS_LVL < 1 || PASS_LVL > MAX_I) begin : g_bad_pass
         $error("PASS_LVL must fit in the counter");
      end
      if (WARN_RST < 0 || WARN_RST > MAX_I) begin : g_bad_warn
         $error("WARN_RST must fit in the counter");
      end
   endgenerate

   node_mode_e       mode_q, mode_n;
   logic             in_bo;
   logic             enter_w;
   logic             done_w;
   logic             rec_step_w;
   logic [CNT_W-1:0] tec_q, rec_q, tec_n, rec_n;
   logic [CNT_W-1:0] lvl_q, lvl_n;
   logic             tx_ovf_w, rx_ovf_w;
   logic             init_q, alert_q, irq_bo_q, irq_al_q;
   lvl_flags_t       flags_w;

   assign in_bo      = (mode_q == MODE_BUSOFF);
   assign enter_w    = tx_ovf_w;
   assign done_w     = in_bo && idle_seq_i && (rec_q == RECOV_V);
   assign rec_step_w = in_bo && idle_seq_i && !done_w;
   assign lvl_n      = lvl_wr_i ? lvl_val_i : lvl_q;

   errcnt_cell #(.CNT_W(CNT_W), .AMT_W(AMT_W), .CARRY_OUT(1'b1)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze_i   (in_bo),
      .inc_i      (tx_inc_i),
      .amt_i      (tx_amt_i),
      .dec_i      (tx_dec_i),
      .step_i     (1'b0),
      .load_one_i (enter_w),
      .clear_i    (done_w),
      .cnt_o      (tec_q),
      .cnt_nxt_o  (tec_n),
      .ovf_o      (tx_ovf_w)
   );

   errcnt_cell #(.CNT_W(CNT_W), .AMT_W(AMT_W), .CARRY_OUT(1'b0)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze_i   (in_bo),
      .inc_i      (rx_inc_i),
      .amt_i      (rx_amt_i),
      .dec_i      (rx_dec_i),
      .step_i     (rec_step_w),
      .load_one_i (enter_w),
      .clear_i    (done_w),
      .cnt_o      (rec_q),
      .cnt_nxt_o  (rec_n),
      .ovf_o      (rx_ovf_w)
   );

   always_comb begin
      mode_n = mode_q;
      if (enter_w)     mode_n = MODE_BUSOFF;
      else if (done_w) mode_n = MODE_RUN;
   end

   errcnt_flags #(.CNT_W(CNT_W), .PASS_LVL(PASS_LVL)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .tec_nxt_i (tec_n),
      .rec_nxt_i (rec_n),
      .lvl_nxt_i (lvl_n),
      .bo_nxt_i  (mode_n == MODE_BUSOFF),
      .flags_o   (flags_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_RUN;
         lvl_q    <= LVL_RV;
         init_q   <= 1'b1;
         alert_q  <= 1'b0;
         irq_bo_q <= 1'b0;
         irq_al_q <= 1'b0;
      end else begin
         mode_q   <= mode_n;
         lvl_q    <= lvl_n;
         irq_bo_q <= enter_w;
         irq_al_q <= done_w;
         if (enter_w)
            init_q <= 1'b1;
         else if (init_wr_i && (init_val_i || !in_bo))
            init_q <= init_val_i;
         if (done_w)
            alert_q <= 1'b1;
         else if (alert_clr_i)
            alert_q <= 1'b0;
      end
   end

   assign tec_o         = tec_q;
   assign rec_o         = rec_q;
   assign warn_o        = flags_w.warn;
   assign passive_o     = flags_w.passive;
   assign busoff_o      = in_bo;
   assign init_o        = init_q;
   assign alert_o       = alert_q;
   assign irq_warn_o    = flags_w.irq_warn;
   assign irq_prewarn_o = flags_w.irq_prewarn;
   assign irq_busoff_o  = irq_bo_q;
   assign irq_alert_o   = irq_al_q;

   logic unused_w;
   assign unused_w = rx_ovf_w;
endmodule

// File: rtl/errcnt_chk.sv
`timescale 1ns/1ps
module errcnt_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             idle_seq_i,
   input logic [CNT_W-1:0] tec_o,
   input logic [CNT_W-1:0] rec_o,
   input logic             warn_o,
   input logic             passive_o,
   input logic             busoff_o,
   input logic             init_o,
   input logic             alert_o,
   input logic             irq_warn_o,
   input logic             irq_busoff_o,
   input logic             irq_prewarn_o,
   input logic             irq_alert_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // R4
   busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busoff_o) |-> (tec_o == ONE) && (rec_o == ONE) && init_o && irq_busoff_o);

   // R5
   busoff_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busoff_o) && !$past(idle_seq_i)) |-> ($stable(tec_o) && $stable(rec_o)));

   // R3
   passive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      passive_o |-> !busoff_o);

   // R7
   prewarn_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_prewarn_o |-> (busoff_o && warn_o));

   // R2
   warn_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_warn_o, irq_prewarn_o}));

   // R8
   recovery_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busoff_o) |-> (alert_o && irq_alert_o && init_o && (tec_o == '0) && (rec_o == '0)));

   // R9
   init_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busoff_o |-> init_o);
endmodule

bind can_errcnt_recovery errcnt_chk #(.CNT_W(CNT_W)) u_errcnt_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .idle_seq_i    (idle_seq_i),
   .tec_o         (tec_o),
   .rec_o         (rec_o),
   .warn_o        (warn_o),
   .passive_o     (passive_o),
   .busoff_o      (busoff_o),
   .init_o        (init_o),
   .alert_o       (alert_o),
   .irq_warn_o    (irq_warn_o),
   .irq_busoff_o  (irq_busoff_o),
   .irq_prewarn_o (irq_prewarn_o),
   .irq_alert_o   (irq_alert_o)
);

// File: tb/tb_can_errcnt_recovery.sv
`timescale 1ns/1ps
module tb_can_errcnt_recovery;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0, idle = 0;
   logic [3:0] tx_amt = 0, rx_amt = 0;
   logic       lvl_wr = 0, init_wr = 0, init_val = 0, alert_clr = 0;
   logic [7:0] lvl_val = 0;
   logic [7:0] tec, rec;
   logic       warn, passive, busoff, init, alert, iw, ib, ip, ia;

   int checks = 0;
   int fails  = 0;

   int m_tec = 0, m_rec = 0, m_lvl = 8'h60;
   int m_bo = 0, m_init = 1, m_alert = 0, m_warn = 0, m_pas = 0;
   int e_iw = 0, e_ib = 0, e_ip = 0, e_ia = 0;

   always #2 clk = ~clk;

   can_errcnt_recovery dut (
      .clk(clk), .rst_n(rst_n),
      .tx_inc_i(tx_inc), .tx_amt_i(tx_amt), .tx_dec_i(tx_dec),
      .rx_inc_i(rx_inc), .rx_amt_i(rx_amt), .rx_dec_i(rx_dec),
      .idle_seq_i(idle), .lvl_wr_i(lvl_wr), .lvl_val_i(lvl_val),
      .init_wr_i(init_wr), .init_val_i(init_val), .alert_clr_i(alert_clr),
      .tec_o(tec), .rec_o(rec), .warn_o(warn), .passive_o(passive),
      .busoff_o(busoff), .init_o(init), .alert_o(alert),
      .irq_warn_o(iw), .irq_busoff_o(ib), .irq_prewarn_o(ip), .irq_alert_o(ia)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // Expected next state, derived from the requirement list
   task automatic model_step();
      int enter, done, was_bo, old_warn;
      was_bo   = m_bo;
      old_warn = m_warn;
      enter = (!m_bo && tx_inc && (m_tec + tx_amt > 255)) ? 1 : 0;
      done  = (m_bo && idle && (m_rec == 128)) ? 1 : 0;
      if (enter) begin
         m_tec = 1; m_rec = 1; m_bo = 1;
      end else if (m_bo) begin
         if (done) begin
            m_tec = 0; m_rec = 0; m_bo = 0;
         end else if (idle) begin
            m_rec = m_rec + 1;
         end
      end else begin
         if (tx_inc)                    m_tec = m_tec + tx_amt;
         else if (tx_dec && m_tec > 0)  m_tec = m_tec - 1;
         if (rx_inc)                    m_rec = (m_rec + rx_amt > 255) ? 255 : m_rec + rx_amt;
         else if (rx_dec && m_rec > 0)  m_rec = m_rec - 1;
      end
      if (enter)                                  m_init = 1;
      else if (init_wr && (init_val || !was_bo))  m_init = init_val;
      if (done)           m_alert = 1;
      else if (alert_clr) m_alert = 0;
      if (lvl_wr) m_lvl = lvl_val;
      m_warn = (m_tec >= m_lvl || m_rec >= m_lvl) ? 1 : 0;
      m_pas  = (!m_bo && (m_tec >= 128 || m_rec >= 128)) ? 1 : 0;
      e_iw = (m_warn && !old_warn && !m_bo) ? 1 : 0;
      e_ip = (m_warn && !old_warn && m_bo) ? 1 : 0;
      e_ib = enter;
      e_ia = done;
   endtask

   task automatic tick();
      int was_bo;
      was_bo = m_bo;
      @(posedge clk);
      #1;
      model_step();
      chk(was_bo ? "R5" : "R1", "tec", tec, m_tec);
      chk(was_bo ? "R6" : "R1", "rec", rec, m_rec);
      chk("R2", "warn", warn, m_warn);
      chk("R2", "irq_warn", iw, e_iw);
      chk("R3", "passive", passive, m_pas);
      chk("R4", "busoff", busoff, m_bo);
      chk("R4", "irq_busoff", ib, e_ib);
      chk("R7", "irq_prewarn", ip, e_ip);
      chk("R9", "init", init, m_init);
      chk(alert_clr ? "R10" : "R8", "alert", alert, m_alert);
      chk("R8", "irq_alert", ia, e_ia);
      tx_inc = 0; tx_dec = 0; rx_inc = 0; rx_dec = 0; idle = 0;
      tx_amt = 0; rx_amt = 0; lvl_wr = 0; init_wr = 0; init_val = 0; alert_clr = 0;
   endtask

   task automatic run_busoff();
      for (int n = 0; n < 60 && m_bo == 0; n++) begin
         tx_inc = 1; tx_amt = 4'd8;
         if (n % 3 == 0) begin rx_inc = 1; rx_amt = 4'd2; end
         tick();
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      chk("R11", "tec", tec, 0);
      chk("R11", "rec", rec, 0);
      chk("R11", "init", init, 1);
      chk("R11", "flags", {warn, passive, busoff, alert}, 0);
      chk("R11", "irqs", {iw, ib, ip, ia}, 0);

      // R1 R2 R3: receive counter sweep through warning, passive and saturation
      for (int i = 0; i < 260; i++) begin rx_inc = 1; rx_amt = 4'd1; tick(); end
      rx_inc = 1; rx_amt = 4'd15; rx_dec = 1; tick();
      // R1 decrement down past zero
      for (int i = 0; i < 260; i++) begin rx_dec = 1; tick(); end
      // R1 every step size on the transmit counter, with decrements between
      for (int a = 1; a < 16; a++) begin
         tx_inc = 1; tx_amt = a[3:0]; tick();
         tx_dec = 1; tick();
      end
      // R1 increment wins over decrement
      tx_inc = 1; tx_amt = 4'd3; tx_dec = 1; tick();
      // R2 lowering and restoring the warning level
      lvl_wr = 1; lvl_val = 8'h10; tick();
      tick();
      lvl_wr = 1; lvl_val = 8'h60; tick();
      // R6 idle strobe ignored outside bus-off
      idle = 1; tick();
      for (int i = 0; i < 130; i++) begin tx_dec = 1; tick(); end

      // R4 bus-off entry, R9 entry wins over INIT clear in the same cycle
      init_wr = 1; init_val = 0; tick();
      for (int n = 0; n < 60 && m_bo == 0; n++) begin
         tx_inc = 1; tx_amt = 4'd8;
         init_wr = 1; init_val = 0;
         tick();
      end
      // R5 R6 R7 R8 R9 recovery with ignored requests and INIT clear attempts
      for (int k = 0; k < 400 && m_bo == 1; k++) begin
         idle = (k % 3 != 1);
         tx_inc = (k % 2 == 0); tx_amt = 4'd8;
         rx_dec = (k % 5 == 0); rx_inc = (k % 7 == 0); rx_amt = 4'd4;
         tx_dec = (k % 4 == 0);
         if (k % 11 == 0) begin init_wr = 1; init_val = 0; end
         tick();
      end
      // R8 INIT stays set after recovery; R10 alert clear
      tick();
      alert_clr = 1; tick();
      init_wr = 1; init_val = 0; tick();
      init_wr = 1; init_val = 1; tick();

      // R10 completion wins over alert clear; R2 warn with lowered level
      run_busoff();
      for (int k = 0; k < 200 && m_bo == 1; k++) begin
         idle = 1;
         if (m_rec == 128) alert_clr = 1;
         tick();
      end
      alert_clr = 1; init_wr = 1; init_val = 0; tick();

      // R7 pre-warning at a programmed level
      lvl_wr = 1; lvl_val = 8'h20; tick();
      run_busoff();
      for (int k = 0; k < 200 && m_bo == 1; k++) begin idle = 1; tick(); end
      tick();

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end
endmodule